// File: doc/BRIEF.md
# Prescaled wrap-around event timer

A bus-mapped 16-bit up-counting timer for event generation. Software picks a start value and an end value. The counter climbs from the start value one step per prescaled tick. On the tick after it reaches the end value it returns to the start value, and on that same tick it raises a sticky wrap flag. That flag, gated by an enable bit, drives a level interrupt. Typical use is a periodic tick source or a one-shot delay: stop the counter, load the start and end values, force a reload, then start it again.

The start and end values are held in write buffers. They reach the active registers only while the counter is halted, so a running period is never disturbed by a half-finished update. A write of any data to the count register reloads the count from the active start value and does not store the data.

Top module: `wrap_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0. Word addresses on `bus_addr`: 0 = control, 1 = count, 2 = end value, 3 = start value. Control bits: [2:0] divider exponent, [4:3] source select, [6] interrupt enable, [7] wrap flag. The other bits read 0.
- R2: With source select 1, the counter advances once every 2^exponent clock cycles. The first step falls on the 2^exponent-th rising edge after the edge on which counting was selected. Any source select other than 1 halts the counter and restarts the divider, so each run begins with a full divide interval.
- R3: A step taken while the count equals the active end value loads the active start value. Any other step adds 1. With start ≤ end, one period therefore spans end − start + 1 steps.
- R4: The wrap flag (control bit 7) becomes 1 on every step that takes the count from the end value to the start value.
- R5: A control write with bit 7 = 0 clears the wrap flag. A control write with bit 7 = 1 leaves the flag as it was. A wrap on the same edge as a clearing write leaves the flag at 1.
- R6: `irq_o` is 1 exactly while the wrap flag and the interrupt enable (control bit 6) are both 1.
- R7: A write of any data to the count register loads the active start value into the count.
- R8: Writes to the start and end registers go to buffers. The buffers are copied into the active registers on every clock edge while source select is not 1. Reads of addresses 2 and 3 return the active values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counting source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 and strobed |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Level interrupt: wrap flag AND enable |

## Verification
A divider that is not restarted, or one that steps at the wrong rate, moves the count read back after a timed run by at least one step. It shows on the first run whose length is not a whole multiple of the divide interval. A wrong wrap target or a wrong reload value shifts the residue modulo the period, and so shows after the first wrap, within end − start + 1 steps. A flag or buffer that updates at the wrong moment shows in the flag bit or in the end-value readback on the access that follows the coincident write.

// File: rtl/wrap_timer.sv
module wrap_timer #(
  parameter int CW  = 16,
  parameter int PSW = 3,
  parameter int AW  = 2,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam int DIVW = (1 << PSW) - 1;

  logic [PSW-1:0]  ps;
  logic [1:0]      csel;
  logic            ie, flag;
  logic [CW-1:0]   cnt, mod_act, init_act, mod_buf, init_buf;
  logic [DIVW-1:0] div;

  wire wr      = bus_sel && bus_we;
  wire wr_ctrl = wr && bus_addr == AW'(0);
  wire wr_cnt  = wr && bus_addr == AW'(1);
  wire wr_mod  = wr && bus_addr == AW'(2);
  wire wr_init = wr && bus_addr == AW'(3);

  wire             run  = csel == 2'd1;
  wire [DIVW-1:0]  mask = (DIVW'(1) << ps) - DIVW'(1);
  wire             tick = run && div == mask;
  wire             wrap = tick && cnt == mod_act;

  assign irq_o = flag && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps <= '0; csel <= '0; ie <= 1'b0; flag <= 1'b0;
      cnt <= '0; mod_act <= '0; init_act <= '0;
      mod_buf <= '0; init_buf <= '0; div <= '0;
    end else begin
      if (run) div <= tick ? '0 : div + 1'b1;
      else     div <= '0;

      if (!run) begin
        mod_act  <= mod_buf;
        init_act <= init_buf;
      end

      if (wr_cnt)    cnt <= init_act;
      else if (tick) cnt <= wrap ? init_act : cnt + 1'b1;

      if (wr_mod)  mod_buf  <= bus_wdata[CW-1:0];
      if (wr_init) init_buf <= bus_wdata[CW-1:0];

      if (wr_ctrl) begin
        ps   <= bus_wdata[PSW-1:0];
        csel <= bus_wdata[4:3];
        ie   <= bus_wdata[6];
      end

      if (wrap)                         flag <= 1'b1;
      else if (wr_ctrl && !bus_wdata[7]) flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(0): begin
        bus_rdata[PSW-1:0] = ps;
        bus_rdata[4:3]     = csel;
        bus_rdata[6]       = ie;
        bus_rdata[7]       = flag;
      end
      AW'(1):  bus_rdata[CW-1:0] = cnt;
      AW'(2):  bus_rdata[CW-1:0] = mod_act;
      default: bus_rdata[CW-1:0] = init_act;
    endcase
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt)); // R2
  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> div == '0); // R2
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_cnt) |=> cnt == $past(init_act)); // R3
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag); // R4
  AST_FLAG_ONLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> !$rose(flag)); // R5
  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(mod_act) && $stable(init_act))); // R8
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(init_act)); // R7
endmodule

// File: tb/wrap_timer_tb.sv
module wrap_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;
  int checks = 0, fails = 0, cycles = 0;

  wrap_timer dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input int ps, input int cs, input bit ie, input bit fl);
    return 32'(ps) | (32'(cs) << 3) | (32'(ie) << 6) | (32'(fl) << 7);
  endfunction

  // Start on edge e0, stop-write data sdat lands on edge eM
  task automatic timed_run(input int ps, input int m, input logic [31:0] sdat);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = ctl(ps, 1, 1'b0, 1'b1);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    repeat (m - 1) @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = sdat;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic setup(input int init, input int md);
    wr(2'd0, 32'h0);
    wr(2'd3, 32'(init));
    wr(2'd2, 32'(md));
    wr(2'd1, 32'hABCD);
  endtask

  logic [31:0] r;

  initial begin
    #(3*CLK_PERIOD) rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R1 reset reg", r, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq_o}, 32'h0);

    // R2 R3 R4 sweep over exponent, window and run length
    for (int ps = 0; ps < 8; ps++)
      for (int pr = 0; pr < 3; pr++)
        for (int k = 0; k < 3; k++)
          for (int j = 0; j < 2; j++) begin
            int init, md, m, t, per;
            init = (pr == 0) ? 0 : (pr == 1) ? 5 : 10;
            md   = (pr == 0) ? 3 : (pr == 1) ? 5 : 17;
            m    = (((k == 0) ? 1 : (k == 1) ? 5 : 13) << ps) + (j ? (1 << ps) - 1 : 0);
            setup(init, md);
            timed_run(ps, m, ctl(ps, 0, 1'b0, 1'b1));
            t = m >> ps;
            per = md - init + 1;
            rd(2'd1, r);
            chk("R3 count after run", r, 32'(init + t % per));
            rd(2'd0, r);
            chk("R4 wrap flag", {31'b0, r[7]}, {31'b0, t >= per});
          end

    // R2 other source selects halt the counter
    setup(2, 40);
    wr(2'd0, ctl(0, 2, 1'b0, 1'b0));
    repeat (20) @(negedge clk);
    wr(2'd0, ctl(0, 3, 1'b0, 1'b0));
    repeat (20) @(negedge clk);
    rd(2'd1, r);
    chk("R2 halted select", r, 32'd2);

    // R5 wrap coincident with a clearing write: wrap on e4
    setup(0, 3);
    timed_run(0, 4, ctl(0, 0, 1'b0, 1'b0));
    rd(2'd0, r);
    chk("R5 set wins over clear", {31'b0, r[7]}, 32'd1);
    // R5 clear one edge after the wrap
    setup(0, 3);
    timed_run(0, 5, ctl(0, 0, 1'b0, 1'b0));
    rd(2'd0, r);
    chk("R5 clear after wrap", {31'b0, r[7]}, 32'd0);
    rd(2'd1, r);
    chk("R3 count after clear run", r, 32'd1);

    // R5 writing 1 keeps, R6 irq gating
    setup(0, 1);
    timed_run(0, 3, ctl(0, 0, 1'b0, 1'b1));
    chk("R6 irq disabled", {31'b0, irq_o}, 32'd0);
    wr(2'd0, ctl(0, 0, 1'b1, 1'b1));
    rd(2'd0, r);
    chk("R5 write 1 keeps flag", {31'b0, r[7]}, 32'd1);
    chk("R6 irq asserted", {31'b0, irq_o}, 32'd1);
    wr(2'd0, ctl(0, 0, 1'b1, 1'b0));
    rd(2'd0, r);
    chk("R5 write 0 clears", {31'b0, r[7]}, 32'd0);
    chk("R6 irq follows flag", {31'b0, irq_o}, 32'd0);

    // R7 count write loads start value
    setup(7, 100);
    timed_run(0, 9, ctl(0, 0, 1'b0, 1'b1));
    rd(2'd1, r);
    chk("R7 counted", r, 32'd16);
    wr(2'd1, 32'h1234);
    rd(2'd1, r);
    chk("R7 reload start", r, 32'd7);

    // R8 buffered registers frozen while running
    setup(0, 50);
    wr(2'd0, ctl(0, 1, 1'b0, 1'b1));
    wr(2'd2, 32'd9);
    wr(2'd3, 32'd4);
    rd(2'd2, r);
    chk("R8 end frozen", r, 32'd50);
    rd(2'd3, r);
    chk("R8 start frozen", r, 32'd0);
    wr(2'd0, 32'h0);
    rd(2'd2, r);
    chk("R8 end applied", r, 32'd9);
    rd(2'd3, r);
    chk("R8 start applied", r, 32'd4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule